// File: doc/BRIEF.md
# Serial Register Port with Interrupt Queue

This block is a serial slave control port for a device's internal registers. A host selects it with an active-low chip select, pulses a serial clock sixteen times, and sends an address byte followed by a data byte, most significant bit first. When the address byte has its top bit clear, the transaction is a write. When chip select returns high after exactly sixteen clocks, the block issues a single-cycle write strobe that carries the address and the data to the register file.

When the top bit of the address is set, the transaction is a read. The block looks up the addressed register through a parallel read port and shifts that byte out during the data byte. The serial output changes on falling serial-clock edges. It is released to high impedance whenever the port is not selected, so several devices can share one return line.

Internal logic raises status events on a request vector. Pending events pull an active-low interrupt low while chip select is high. Selecting the port releases the interrupt. A read of the status address reports the lowest-indexed pending event and, once the transaction completes, removes that event from the queue. All serial inputs are synchronised into the system clock. The system clock runs at least four times faster than the serial clock.

Top module: `mw_regport`

## Requirements
- R1: A transaction with exactly 16 serial clocks and address bit 7 = 0 produces a write strobe. The strobe carries the first byte as the address and the second byte as the data, each sent MSB first and sampled on rising serial-clock edges.
- R2: The write strobe lasts exactly one system clock. It appears only after chip select has returned high, never while the port is still selected.
- R3: If chip select rises after any number of serial clocks other than 16, the transaction is discarded. No strobe is issued and the event queue is not changed.
- R4: A transaction with address bit 7 = 1 issues no strobe. During the data byte, the port drives `rd_data` (looked up at `rd_addr` = the address byte) onto `sdo`, MSB first. `sdo` changes on falling serial-clock edges, so each bit is valid for the following rising edge.
- R5: `sdo_oe` is 0 and `sdo` is high impedance whenever chip select is high. `sdo_oe` is 1 while the port is enabled and selected.
- R6: While any event is pending and chip select is high, `irq_n` is low. A pulse on `ev_req[i]` marks event i pending.
- R7: Pulling chip select low releases `irq_n` high within three system clocks. If events remain pending, `irq_n` goes low again after chip select returns high.
- R8: A read of the status address (default 8'h80) returns {1, zeros, index} for the lowest-indexed pending event. It returns 8'h00 when no event is pending.
- R9: A completed status read removes the reported event from the queue. An aborted status read removes nothing.
- R10: With `en_strap` low, the port ignores transactions, keeps `sdo_oe` low and holds `irq_n` high. Events still queue and are signalled once the strap is raised.
- R11: After reset, `irq_n` = 1, `wr_stb` = 0 and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_strap | input | 1 | Port enable strap |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high impedance when not selected |
| sdo_oe | output | 1 | Output enable for sdo |
| irq_n | output | 1 | Active-low interrupt |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| rd_addr | output | 8 | Address for parallel read lookup |
| rd_data | input | 8 | Read data for rd_addr |
| ev_req | input | NEV | Event request pulses, index 0 highest priority |

## Verification
The assertions take four things for granted about the inputs:
- Chip select stays high for several system clocks after each transaction ends.
- Each serial clock level lasts well beyond the two-stage synchroniser.
- `en_strap` does not toggle in the middle of a transaction.
- The write strobe is therefore expected only while the raw chip select is high.

The bench meets these conditions by driving every serial level for eight system clocks. It holds chip select idle for at least a dozen clocks between transactions, and changes the strap only while the port is idle.

// File: rtl/mw_regport.sv
module mw_regport #(
  parameter int          NEV       = 4,
  parameter logic [7:0]  STAT_ADDR = 8'h80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_strap,
  input  logic           sclk,
  input  logic           cs_n,
  input  logic           sdi,
  output logic           sdo,
  output logic           sdo_oe,
  output logic           irq_n,
  output logic           wr_stb,
  output logic [7:0]     wr_addr,
  output logic [7:0]     wr_data,
  output logic [7:0]     rd_addr,
  input  logic [7:0]     rd_data,
  input  logic [NEV-1:0] ev_req
);
  localparam int IW = (NEV > 1) ? $clog2(NEV) : 1;

  logic [2:0]     sck_p, cs_p;
  logic [1:0]     sdi_p;
  logic           sel_q;
  logic [15:0]    isr;
  logic [4:0]     cnt;
  logic [7:0]     osr;
  logic           rep_vld;
  logic [IW-1:0]  rep_idx, top_idx;
  logic [NEV-1:0] pend, clr;

  wire sel_d    = en_strap & ~cs_p[1];
  wire sel_fall = sel_d & ~sel_q;
  wire sel_rise = ~sel_d & sel_q;
  wire sck_r    = sel_d & sck_p[1] & ~sck_p[2];
  wire sck_f    = sel_d & ~sck_p[1] & sck_p[2];
  wire commit   = sel_rise & en_strap & (cnt == 5'd16);
  wire any_p    = |pend;
  wire is_stat  = (isr[15:8] == STAT_ADDR);
  wire [7:0] stat_byte = any_p ? {1'b1, {(7-IW){1'b0}}, top_idx} : 8'h00;

  assign rd_addr = isr[7:0];
  assign sdo_oe  = en_strap & ~cs_n;
  assign sdo     = sdo_oe ? osr[7] : 1'bz;

  always_comb begin
    top_idx = '0;
    for (int i = NEV-1; i >= 0; i--)
      if (pend[i]) top_idx = IW'(i);
  end

  always_comb begin
    clr = '0;
    if (commit && is_stat && rep_vld) clr[rep_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0; cs_p <= '1; sdi_p <= '0; sel_q <= 1'b0;
      isr <= '0; cnt <= '0; osr <= '0; rep_vld <= 1'b0; rep_idx <= '0;
      pend <= '0; irq_n <= 1'b1;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sclk};
      cs_p  <= {cs_p[1:0], cs_n};
      sdi_p <= {sdi_p[0], sdi};
      sel_q <= sel_d;
      wr_stb <= 1'b0;
      if (sel_fall) begin
        cnt <= '0; osr <= '0; rep_vld <= 1'b0;
      end else begin
        if (sck_r) begin
          isr <= {isr[14:0], sdi_p[1]};
          if (cnt != 5'd31) cnt <= cnt + 5'd1;
        end
        if (sck_f) begin
          if (cnt == 5'd8) begin
            osr     <= (isr[7:0] == STAT_ADDR) ? stat_byte : rd_data;
            rep_vld <= (isr[7:0] == STAT_ADDR) && any_p;
            rep_idx <= top_idx;
          end else begin
            osr <= {osr[6:0], 1'b0};
          end
        end
      end
      if (commit && !isr[15]) begin
        wr_stb  <= 1'b1;
        wr_addr <= isr[15:8];
        wr_data <= isr[7:0];
      end
      pend  <= (pend & ~clr) | ev_req;
      irq_n <= ~(en_strap & any_p & cs_p[1]);
    end
  end
endmodule

// File: rtl/mw_regport_chk.sv
module mw_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_strap,
  input logic       cs_n,
  input logic       irq_n,
  input logic       wr_stb,
  input logic [7:0] wr_addr
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r2_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> cs_n);

  a_r1_write_space: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !wr_addr[7]);

  a_r7_irq_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && $past(!cs_n, 2) && $past(!cs_n, 3)) |-> irq_n);

  a_r10_strap_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_strap |=> (irq_n && !wr_stb));
endmodule

bind mw_regport mw_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_strap(en_strap), .cs_n(cs_n),
  .irq_n(irq_n), .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/tb_mw_regport.sv
module tb_mw_regport;
  logic clk = 1'b0, rst_n = 1'b0, en_strap = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, irq_n, wr_stb;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [3:0] ev_req = '0;

  int tests = 0, fails = 0, nstb = 0, pre_stb = 0;
  logic [7:0] la = '0, ld = '0, rb;

  always #2 clk = ~clk;
  assign rd_data = rd_addr ^ 8'h5A;

  mw_regport dut (.clk(clk), .rst_n(rst_n), .en_strap(en_strap), .sclk(sclk),
    .cs_n(cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .irq_n(irq_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_req(ev_req));

  always @(negedge clk) if (wr_stb) begin nstb++; la = wr_addr; ld = wr_data; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic waitc(input int n); repeat (n) @(negedge clk); endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int n, output logic [7:0] r);
    logic [15:0] w;
    w = {a, d}; r = '0;
    cs_n = 1'b0; waitc(8);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      waitc(8);
      if (i >= 8 && i < 16) r = {r[6:0], sdo};
      sclk = 1'b1; waitc(8);
      sclk = 1'b0;
    end
    waitc(8);
    pre_stb = nstb;
    cs_n = 1'b1; waitc(14);
  endtask

  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {8'h12, 8'h34, 1'b1, 8'h00},
    {8'h7F, 8'h00, 1'b1, 8'h00},
    {8'h00, 8'hFF, 1'b1, 8'h00},
    {8'h85, 8'h00, 1'b0, 8'hDF},
    {8'hC0, 8'hAA, 1'b0, 8'h9A},
    {8'h80, 8'h00, 1'b0, 8'h00}
  };

  initial begin
    int s0;
    waitc(4); rst_n = 1'b1; waitc(3);
    chk(irq_n == 1'b1, "R11 irq_n", irq_n, 1);
    chk(wr_stb == 1'b0, "R11 wr_stb", wr_stb, 0);
    chk(sdo_oe == 1'b0, "R5 sdo_oe idle", sdo_oe, 0);

    for (int v = 0; v < NV; v++) begin
      s0 = nstb;
      xfer(VEC[v][24:17], VEC[v][16:9], 16, rb);
      if (VEC[v][8]) begin
        chk(pre_stb == s0, "R2 no strobe before deselect", pre_stb - s0, 0);
        chk(nstb == s0 + 1, "R2 one strobe", nstb - s0, 1);
        chk(la == VEC[v][24:17], "R1 addr", la, VEC[v][24:17]);
        chk(ld == VEC[v][16:9], "R1 data", ld, VEC[v][16:9]);
      end else begin
        chk(nstb == s0, "R4 no strobe on read", nstb - s0, 0);
        chk(rb == VEC[v][7:0], "R4/R8 read byte", rb, VEC[v][7:0]);
      end
    end

    s0 = nstb; xfer(8'h21, 8'h43, 15, rb);
    chk(nstb == s0, "R3 15 clocks discarded", nstb - s0, 0);
    s0 = nstb; xfer(8'h21, 8'h43, 17, rb);
    chk(nstb == s0, "R3 17 clocks discarded", nstb - s0, 0);

    cs_n = 1'b0; waitc(4);
    chk(sdo_oe == 1'b1, "R5 sdo_oe selected", sdo_oe, 1);
    cs_n = 1'b1; waitc(12);

    ev_req = 4'b0100; waitc(1); ev_req = 4'b0010; waitc(1); ev_req = '0; waitc(4);
    chk(irq_n == 1'b0, "R6 irq asserted", irq_n, 0);
    cs_n = 1'b0; waitc(4);
    chk(irq_n == 1'b1, "R7 irq released on select", irq_n, 1);
    cs_n = 1'b1; waitc(6);
    chk(irq_n == 1'b0, "R7 irq reasserts", irq_n, 0);
    xfer(8'h80, 8'h00, 16, rb);
    chk(rb == 8'h81, "R8 lowest index first", rb, 8'h81);
    chk(irq_n == 1'b0, "R9 remaining event", irq_n, 0);
    xfer(8'h80, 8'h00, 15, rb);
    xfer(8'h80, 8'h00, 16, rb);
    chk(rb == 8'h82, "R9 aborted read kept event", rb, 8'h82);
    chk(irq_n == 1'b1, "R9 queue empty", irq_n, 1);
    xfer(8'h80, 8'h00, 16, rb);
    chk(rb == 8'h00, "R8 empty status", rb, 8'h00);

    en_strap = 1'b0; waitc(4);
    s0 = nstb; xfer(8'h22, 8'h33, 16, rb);
    chk(nstb == s0, "R10 write ignored", nstb - s0, 0);
    cs_n = 1'b0; waitc(4);
    chk(sdo_oe == 1'b0, "R10 sdo_oe off", sdo_oe, 0);
    cs_n = 1'b1; waitc(12);
    ev_req = 4'b1000; waitc(1); ev_req = '0; waitc(6);
    chk(irq_n == 1'b1, "R10 irq held high", irq_n, 1);
    en_strap = 1'b1; waitc(6);
    chk(irq_n == 1'b0, "R10 event signalled after enable", irq_n, 0);
    xfer(8'h80, 8'h00, 16, rb);
    chk(rb == 8'h83, "R8 status index 3", rb, 8'h83);
    chk(irq_n == 1'b1, "R9 dequeued", irq_n, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #600000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule